// File: doc/BRIEF.md
# Cascadable Binary Rate Multiplier

The block thins a clock into a pulse stream whose average rate is a programmed fraction of the clock rate. Each stage has a free-running 4-bit slot counter. Each bit of that stage's 4-bit rate word owns a fixed, disjoint set of counter states. A stage programmed with N emits exactly N single-cycle pulses in every 16 enabled clocks.

Several stages are chained inside one top module to reach wider rate words. The chain has two modes:

- **Add mode:** a less significant stage advances only when every more significant stage sits at count 15, and it may pulse only in that slot. The rates sum to `N0/16 + N1/256`.
- **Multiply mode:** each stage advances only on the clocks where the stage before it pulses, so the rates multiply.

Beyond the rate word and the mode, the chain has three control pins:

- An inhibit input freezes every counter and suppresses the output.
- A force input loads all counters with 15.
- A detect output reports that every counter holds 15.

No data stream crosses the block, so there is no valid/ready handshake. All pins are plain control or status pins.

Top module: `brm_chain`

## Requirements
- R1: With the chain in add mode (`mode_mul`=0) and the lower stage programmed to 0, `pulse_out` carries exactly `N0*16` pulses in every 256 consecutive clocks. `N0` is `rate[7:4]` and is the most significant stage.
- R2: With `N0`=13 and the lower stage at 0, every window of 16 consecutive clocks holds exactly 13 pulses.
- R3: Each rate bit of a stage owns its own counter states, and no two bits share a state:
  - bit 3 owns every even count;
  - bit 2 owns counts 1, 5, 9 and 13;
  - bit 1 owns counts 3 and 11;
  - bit 0 owns count 7.
  Bits 3, 2, 1 and 0 therefore give 8, 4, 2 and 1 pulses per 16 clocks.
- R4: When several rate bits are set, the output is the union of their individual slot sets.
- R5: While `set_max` is high, every stage counter loads 15 at the clock edge. `term_out` is 1 exactly while all counters hold 15.
- R6: In add mode, the lower stage advances and pulses only in the slot where the upper stage is at 15. The chain yields `N0*16+N1` pulses per 256 clocks; for example 11 and 13 give 189.
- R7: In multiply mode (`mode_mul`=1), the lower stage advances only on clocks where the upper stage pulses. Only the lower stage's pulses reach the output, so the chain yields `N0*N1` pulses per 256 clocks; for example 11 and 13 give 143.
- R8: While `inhibit` is high, no counter changes and `pulse_out` stays 0. After release, the slot sequence resumes from the frozen count.
- R9: A rate of 0 produces no pulses. A single stage at 15 pulses in slots 0 to 14 and is empty in slot 15.
- R10: `pulse_out` is registered, one clock wide, and reports the slot decided in the previous cycle. After reset, `pulse_out` and `term_out` are 0 and all counters start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one input pulse |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_mul | input | 1 | 0 selects add cascade, 1 selects multiply cascade |
| inhibit | input | 1 | Freezes all counters and blocks the output |
| set_max | input | 1 | Loads every stage counter with 15 |
| rate | input | 8 | Rate words, stage 0 (most significant) in bits 7:4 |
| pulse_out | output | 1 | Registered output pulse stream |
| term_out | output | 1 | High while every stage counter holds 15 |

## Verification
A slot decoder with a wrong owner for one rate bit shows up as a misplaced pulse within 16 clocks after a force-to-15, and as a wrong total over the next 256-clock window. A cascade enable taken from the wrong stage, or from the wrong mode, leaves the single-stage patterns intact but gives a wrong 256-clock count: for example 176 instead of 189, or 189 instead of 143. A counter that keeps moving under inhibit, or a missing output gate, shows as a wrong bit during the inhibited cycles or within three cycles after release.

// File: rtl/brm_pkg.sv
package brm_pkg;
  localparam int SLOT_W = 4;
  localparam int CHAIN_STAGES = 2;

  typedef enum logic {
    CHAIN_ADD = 1'b0,
    CHAIN_MUL = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/brm_slot_decode.sv
module brm_slot_decode #(
  parameter int W = brm_pkg::SLOT_W
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] rate,
  output logic [W-1:0] hits,
  output logic         any_hit
);
  logic [W-1:0] slot_match;

  // Bit j owns counts whose lowest (W-1-j) bits are ones and whose next bit is zero.
  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam int LOW = W - 1 - j;
    logic m;
    always_comb begin
      m = ~count[LOW];
      for (int i = 0; i < LOW; i++) m = m & count[i];
    end
    assign slot_match[j] = m;
  end

  assign hits    = slot_match & rate;
  assign any_hit = |hits;

  always_comb begin
    assert_slots_disjoint_R3: assert ($isunknown(hits) || $onehot0(hits));
  end
endmodule

// File: rtl/brm_stage.sv
module brm_stage #(
  parameter int W = brm_pkg::SLOT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load_max,
  input  logic [W-1:0] rate,
  output logic [W-1:0] count,
  output logic         at_max,
  output logic         any_hit
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] hits;

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (load_max) count <= MAXV;
    else if (adv)      count <= count + 1'b1;
  end

  assign at_max = (count == MAXV);

  brm_slot_decode #(.W(W)) u_dec (
    .count  (count),
    .rate   (rate),
    .hits   (hits),
    .any_hit(any_hit)
  );

  assert_load_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_max |=> at_max);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load_max) |=> $stable(count));

  assert_gap_at_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |-> !any_hit);
endmodule

// File: rtl/brm_chain.sv
module brm_chain #(
  parameter int STAGES = brm_pkg::CHAIN_STAGES,
  parameter int W      = brm_pkg::SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_mul,
  input  logic                  inhibit,
  input  logic                  set_max,
  input  logic [STAGES*W-1:0]   rate,
  output logic                  pulse_out,
  output logic                  term_out
);
  import brm_pkg::*;

  localparam int RW = STAGES * W;

  chain_mode_e     mode;
  logic [STAGES-1:0] en;
  logic [STAGES-1:0] fire;
  logic [STAGES-1:0] at_max;
  logic [STAGES-1:0] hit;
  logic              combined;

  assign mode  = chain_mode_e'(mode_mul);
  assign en[0] = ~inhibit;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] cnt;

    if (k > 0) begin : g_link
      assign en[k] = (mode == CHAIN_MUL) ? fire[k-1] : (en[k-1] & at_max[k-1]);

      assert_add_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CHAIN_ADD && fire[k]) |-> at_max[k-1]);
    end

    brm_stage #(.W(W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (en[k]),
      .load_max(set_max),
      .rate    (rate[RW-1-k*W -: W]),
      .count   (cnt),
      .at_max  (at_max[k]),
      .any_hit (hit[k])
    );

    assign fire[k] = en[k] & hit[k];
  end

  assign combined = (mode == CHAIN_MUL) ? fire[STAGES-1] : (|fire);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_out <= 1'b0;
    else        pulse_out <= combined;
  end

  assign term_out = &at_max;

  assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !pulse_out);

  assert_set_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_max |=> term_out);

  assert_mul_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_mul && !fire[0]) |=> !pulse_out);

  assert_zero_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> !pulse_out);

  assert_registered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fire) |=> !pulse_out);
endmodule

// File: tb/brm_chain_test.sv
module brm_chain_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_mul = 1'b0;
  logic       inhibit = 1'b0;
  logic       set_max = 1'b0;
  logic [7:0] rate = 8'h00;
  logic       pulse_out;
  logic       term_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycnt = 0;
  int cum = 0;
  int cumhist [int];

  // kind: 0 = pulse bit, 1 = term bit, 2 = window pulse count
  typedef struct {
    int    kind;
    int    cyc;
    int    start;
    int    val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  brm_chain uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_mul (mode_mul),
    .inhibit  (inhibit),
    .set_max  (set_max),
    .rate     (rate),
    .pulse_out(pulse_out),
    .term_out (term_out)
  );

  task automatic check(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cycnt);
    end
  endtask

  // Monitor: pops expected items as the design produces results.
  always @(posedge clk) begin
    cycnt++;
    #2;
    cum += int'(pulse_out);
    cumhist[cycnt] = cum;
    while (q.size() > 0 && q[0].cyc <= cycnt) begin
      exp_t e;
      e = q.pop_front();
      case (e.kind)
        0: check(e.tag, int'(pulse_out), e.val);
        1: check(e.tag, int'(term_out), e.val);
        default: check(e.tag, cumhist[e.cyc] - cumhist[e.start], e.val);
      endcase
    end
  end

  function automatic bit slot_on(logic [3:0] r, logic [3:0] s);
    return (r[3] && s[0] == 1'b0) || (r[2] && s[1:0] == 2'b01) ||
           (r[1] && s[2:0] == 3'b011) || (r[0] && s == 4'd7);
  endfunction

  task automatic push(int kind, int cyc, int start, int val, string tag);
    exp_t e;
    e.kind = kind; e.cyc = cyc; e.start = start; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // Force to 15, then predict each slot's output bit from the requirements.
  task automatic run_seq(logic [7:0] r, bit mm, int n, string tag);
    int c;
    logic [3:0] m0, m1;
    bit f0, o;
    @(negedge clk);
    rate = r; mode_mul = mm; set_max = 1'b1;
    c = cycnt;
    push(1, c + 1, 0, 1, {tag, " term after force"});
    @(negedge clk);
    set_max = 1'b0;
    m0 = 4'hF; m1 = 4'hF;
    for (int i = 0; i < n; i++) begin
      f0 = slot_on(r[7:4], m0);
      if (!mm) begin
        o = f0 || (m0 == 4'hF && slot_on(r[3:0], m1));
        if (m0 == 4'hF) m1 = m1 + 1'b1;
      end else begin
        o = f0 && slot_on(r[3:0], m1);
        if (f0) m1 = m1 + 1'b1;
      end
      m0 = m0 + 1'b1;
      push(0, c + 2 + i, 0, int'(o), tag);
    end
    repeat (n + 1) @(negedge clk);
  endtask

  task automatic run_win(logic [7:0] r, bit mm, int len, int nwin, int expv, string tag);
    int s;
    @(negedge clk);
    rate = r; mode_mul = mm;
    repeat (3) @(negedge clk);
    s = cycnt;
    for (int w = 0; w < nwin; w++)
      push(2, s + (w + 1) * len, s + w * len, expv, tag);
    repeat (len * nwin + 1) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c;
    rate = 8'hFF;
    repeat (4) @(negedge clk);
    check("R10 reset pulse_out", int'(pulse_out), 0);
    check("R10 reset term_out", int'(term_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 term after reset", int'(term_out), 0);

    // Slot patterns after a force to 15.
    run_seq(8'h80, 1'b0, 18, "R3 bit3 even slots");
    run_seq(8'h40, 1'b0, 18, "R3 bit2 slots");
    run_seq(8'h20, 1'b0, 18, "R3 bit1 slots");
    run_seq(8'h10, 1'b0, 18, "R3 bit0 slot");
    run_seq(8'hA0, 1'b0, 34, "R4 union 1010");
    run_seq(8'hF0, 1'b0, 34, "R9 rate15 gap at 15");
    run_seq(8'hBD, 1'b0, 300, "R6 add fill sequence");
    run_seq(8'hFF, 1'b1, 40, "R7 multiply sequence");

    // Pulse counts per window.
    run_win(8'h80, 1'b0, 256, 1, 128, "R1 N0=8");
    run_win(8'hD0, 1'b0, 256, 1, 208, "R1 N0=13");
    run_win(8'hD0, 1'b0, 16, 4, 13, "R2 13 per 16");
    run_win(8'h50, 1'b0, 256, 1, 80, "R4 N0=5 union");
    run_win(8'hBD, 1'b0, 256, 1, 189, "R6 add 11,13");
    run_win(8'hF1, 1'b0, 256, 1, 241, "R6 add 15,1");
    run_win(8'hBD, 1'b1, 256, 1, 143, "R7 mul 11,13");
    run_win(8'hF7, 1'b1, 256, 1, 105, "R7 mul 15,7");
    run_win(8'h3F, 1'b1, 256, 1, 45, "R7 mul 3,15");
    run_win(8'h00, 1'b0, 256, 1, 0, "R9 zero rate");
    run_win(8'hF0, 1'b0, 256, 1, 240, "R9 N0=15");

    // Inhibit: freeze at count 2 for three cycles.
    @(negedge clk);
    rate = 8'h80; mode_mul = 1'b0; set_max = 1'b1;
    c = cycnt;
    @(negedge clk);
    set_max = 1'b0;
    push(0, c + 2, 0, 0, "R8 pre slot15");
    push(0, c + 3, 0, 1, "R8 pre slot0");
    push(0, c + 4, 0, 0, "R8 pre slot1");
    repeat (3) @(negedge clk);
    inhibit = 1'b1;
    push(0, c + 5, 0, 0, "R8 inhibited out");
    push(0, c + 6, 0, 0, "R8 inhibited out");
    push(0, c + 7, 0, 0, "R8 inhibited out");
    push(1, c + 7, 0, 0, "R8 term while frozen");
    repeat (3) @(negedge clk);
    inhibit = 1'b0;
    push(0, c + 8, 0, 1, "R8 resume slot2");
    push(0, c + 9, 0, 0, "R8 resume slot3");
    push(0, c + 10, 0, 1, "R8 resume slot4");
    repeat (5) @(negedge clk);

    repeat (3) @(negedge clk);
    check("scoreboard drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule